// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This engine drains a byte stream of received frames into memory buffers that software lays out as a ring of descriptors. Before each frame it reads the current descriptor through a simple memory master port. It goes on only when the descriptor's ownership bit grants the slot to hardware. It then stores the frame bytes at the buffer pointer, bounded by the capacity in the descriptor. When the frame ends it writes a status word that releases the slot to software, and it moves to the next slot, or back to the ring base when the slot carries the end-of-ring mark.

Each descriptor is 16 bytes and starts on a 16-byte boundary. Word 0, at offset 0, is the control/status word. Word 1, at offset 4, holds the capacity in bits [10:0] and the end-of-ring mark in bit 31. Word 2, at offset 8, is the buffer address. A receive buffer address is legal only when bits [1:0] equal 2'b10, that is on a 2-byte boundary that is not a 4-byte boundary. Frames flagged as errored, and frames shorter than `MIN_LEN`, can be kept or thrown away under two enables. A frame that is thrown away leaves its slot owned by hardware, and the next frame refills that same slot.

The memory port is fire-and-forget for writes. A read returns `mem_rdata` with `mem_rvalid` in the cycle after the request.

Top module: `rxr_ring_writer`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `in_ready` and `mem_req` are low.
- R2: If bit 31 of descriptor word 0 is clear, the engine writes nothing and keeps `in_ready` low. It re-reads the word until the bit is set, and then takes the waiting frame into that slot. Descriptor words are read only at offsets 0, 4 and 8, and never while a frame is streaming.
- R3: Byte i of a frame is written to buffer address + i. `mem_be` is one-hot on lane address[1:0], and `mem_wdata` carries the byte replicated in all four lanes.
- R4: On release, word 0 is written with `mem_be`=4'hF. Bits [10:0] hold the count of received bytes, bit 16 flags a frame error, bit 17 a runt, bit 18 an overflow and bit 19 a bad buffer address. Bit 31 (ownership) is 0.
- R5: After a release the next slot is at the current descriptor + 16. If word 1 bit 31 of the used slot is set, the next slot is at the ring base instead. All word writes are 16-byte aligned.
- R6: A buffer address whose bits [1:0] are not 2'b10 (odd, or 4-byte aligned) causes no buffer writes. The slot is still released with bit 19 set.
- R7: Bytes past the capacity in word 1 bits [10:0] are not written. The slot is released with bit 18 set, and the length field still counts every received byte.
- R8: A frame with `in_err` on any accepted byte is released with bit 16 set when `accept_all`=1. When `accept_all`=0 it is discarded: word 0 is not written and the slot is not advanced.
- R9: A frame shorter than `MIN_LEN` bytes is released with bit 17 set when `accept_runt`=1, and is discarded as in R8 when it is 0. A frame of exactly `MIN_LEN` bytes is not a runt.
- R10: With `en` low and no frame in progress, the engine issues no reads and keeps `in_ready` low, and its slot pointer returns to `ring_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Engine enable, sampled between frames |
| accept_all | input | 1 | Keep frames that carry an error flag |
| accept_runt | input | 1 | Keep frames shorter than MIN_LEN |
| ring_base | input | AW | Address of the first descriptor |
| in_valid | input | 1 | Frame byte present |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Byte is the final byte of the frame |
| in_err | input | 1 | Frame error indication on this byte |
| in_ready | output | 1 | Byte accepted this cycle when in_valid is high |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The hardest cases to reach from the ports are those where a frame must leave no trace: a discarded frame, a stalled frame waiting on a slot that software still owns, and a misaligned buffer. The memory model counts byte writes, word writes and reads, so the bench can show that a period passed with no traffic. It holds a frame at the input while software owns the slot, and holds one again while the enable is low. A discarded frame is confirmed when the next frame lands in the same slot, and the return to the base is confirmed when a frame lands in the first slot after the enable is raised again.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int LEN_W      = 11;
    localparam int DESC_BYTES = 16;
    localparam int OWN_BIT    = 31;
    localparam int EOR_BIT    = 31;
    localparam int FERR_BIT   = 16;
    localparam int RUNT_BIT   = 17;
    localparam int OVF_BIT    = 18;
    localparam int ALGN_BIT   = 19;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD_CTL, ST_RD_CAP, ST_RD_BUF, ST_DATA, ST_DONE
    } rx_state_t;

    typedef struct packed {
        logic             eor;
        logic [LEN_W-1:0] cap;
    } slot_cfg_t;

    // legal receive buffer: half-word aligned but not word aligned
    function automatic logic buf_addr_ok(input logic [1:0] lo);
        return lo == 2'b10;
    endfunction
endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr
    import rxr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] base,
    input  logic          park,
    input  logic          advance,
    input  logic          wrap,
    output logic [AW-1:0] cur
);
    localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

    always_ff @(posedge clk) begin
        if (rst || park)
            cur <= base;
        else if (advance)
            cur <= wrap ? base : cur + STEP;
    end
endmodule

// File: rtl/rxr_frame_acc.sv
module rxr_frame_acc
    import rxr_pkg::*;
#(
    parameter int MIN_LEN = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             take,
    input  logic             byte_err,
    input  logic [LEN_W-1:0] cap,
    input  logic             aligned,
    input  logic             accept_all,
    input  logic             accept_runt,
    output logic             store_ok,
    output logic [LEN_W-1:0] count,
    output logic [31:0]      status,
    output logic             discard
);
    logic ferr, ovf, runt, room;

    assign room     = count < cap;
    assign store_ok = aligned && room;
    assign runt     = int'(count) < MIN_LEN;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
            ferr  <= 1'b0;
            ovf   <= 1'b0;
        end else if (take) begin
            if (count != '1)
                count <= count + 1'b1;
            if (byte_err)
                ferr <= 1'b1;
            if (!room)
                ovf <= 1'b1;
        end
    end

    always_comb begin
        status              = '0;
        status[LEN_W-1:0]   = count;
        status[FERR_BIT]    = ferr;
        status[RUNT_BIT]    = runt;
        status[OVF_BIT]     = ovf;
        status[ALGN_BIT]    = !aligned;
        status[OWN_BIT]     = 1'b0;
        discard = (ferr && !accept_all) || (runt && !accept_runt);
    end
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer
    import rxr_pkg::*;
#(
    parameter int AW      = 32,
    parameter int MIN_LEN = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          accept_all,
    input  logic          accept_runt,
    input  logic [AW-1:0] ring_base,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    input  logic          in_err,
    output logic          in_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    output logic [3:0]    mem_be,
    input  logic          mem_rvalid,
    input  logic [31:0]   mem_rdata
);
    rx_state_t        state, state_n;
    logic             rd_pend;
    slot_cfg_t        cfg;
    logic [AW-1:0]    buf_base, cur, waddr;
    logic [LEN_W-1:0] count, cap_q;
    logic [31:0]      status;
    logic             store_ok, discard, aligned, take, got;
    logic             park, advance, clear;

    assign aligned = buf_addr_ok(buf_base[1:0]);
    assign take    = in_ready && in_valid;
    assign got     = rd_pend && mem_rvalid;
    assign park    = (state == ST_IDLE) && !en;
    assign clear   = (state == ST_RD_BUF);
    assign advance = (state == ST_DONE) && !discard;
    assign waddr   = buf_base + AW'(count);
    assign cap_q   = cfg.cap;

    rxr_ring_ptr #(.AW(AW)) u_ptr (
        .clk(clk), .rst(rst), .base(ring_base), .park(park),
        .advance(advance), .wrap(cfg.eor), .cur(cur)
    );

    rxr_frame_acc #(.MIN_LEN(MIN_LEN)) u_acc (
        .clk(clk), .rst(rst), .clear(clear), .take(take), .byte_err(in_err),
        .cap(cfg.cap), .aligned(aligned), .accept_all(accept_all),
        .accept_runt(accept_runt), .store_ok(store_ok), .count(count),
        .status(status), .discard(discard)
    );

    always_comb begin
        state_n   = state;
        in_ready  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur;
        mem_wdata = {4{in_data}};
        mem_be    = 4'h0;
        unique case (state)
            ST_IDLE: if (en && in_valid) state_n = ST_RD_CTL;
            ST_RD_CTL: begin
                mem_req = !rd_pend;
                if (got) state_n = mem_rdata[OWN_BIT] ? ST_RD_CAP : ST_IDLE;
            end
            ST_RD_CAP: begin
                mem_req  = !rd_pend;
                mem_addr = cur + AW'(4);
                if (got) state_n = ST_RD_BUF;
            end
            ST_RD_BUF: begin
                mem_req  = !rd_pend;
                mem_addr = cur + AW'(8);
                if (got) state_n = ST_DATA;
            end
            ST_DATA: begin
                in_ready = 1'b1;
                if (in_valid && store_ok) begin
                    mem_req  = 1'b1;
                    mem_we   = 1'b1;
                    mem_addr = waddr;
                    mem_be   = 4'b0001 << waddr[1:0];
                end
                if (take && in_last) state_n = ST_DONE;
            end
            ST_DONE: begin
                if (!discard) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_wdata = status;
                    mem_be    = 4'hF;
                end
                state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            rd_pend  <= 1'b0;
            cfg      <= '0;
            buf_base <= '0;
        end else begin
            state <= state_n;
            if (got)
                rd_pend <= 1'b0;
            else if (mem_req && !mem_we)
                rd_pend <= 1'b1;
            if (got && state == ST_RD_CAP)
                cfg <= '{eor: mem_rdata[EOR_BIT], cap: mem_rdata[LEN_W-1:0]};
            if (got && state == ST_RD_BUF)
                buf_base <= mem_rdata[AW-1:0];
        end
    end
endmodule

// File: rtl/rxr_ring_writer_chk.sv
module rxr_ring_writer_chk
    import rxr_pkg::*;
#(
    parameter int AW = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             in_ready,
    input logic             mem_req,
    input logic             mem_we,
    input logic [AW-1:0]    mem_addr,
    input logic [31:0]      mem_wdata,
    input logic [3:0]       mem_be,
    input logic [AW-1:0]    buf_base,
    input logic [LEN_W-1:0] cap_q
);
    logic byte_wr, word_wr, rd;
    assign byte_wr = mem_req && mem_we && (mem_be != 4'hF);
    assign word_wr = mem_req && mem_we && (mem_be == 4'hF);
    assign rd      = mem_req && !mem_we;

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!in_ready && !mem_req));

    a_r2_no_read_while_streaming: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !rd);

    a_r3_single_lane: assert property (@(posedge clk) disable iff (rst)
        byte_wr |-> ($countones(mem_be) == 1 && mem_be == (4'b0001 << mem_addr[1:0])));

    a_r4_release_clears_owner: assert property (@(posedge clk) disable iff (rst)
        word_wr |-> !mem_wdata[OWN_BIT]);

    a_r5_word_write_aligned: assert property (@(posedge clk) disable iff (rst)
        word_wr |-> (mem_addr[3:0] == 4'h0));

    a_r5_read_offsets: assert property (@(posedge clk) disable iff (rst)
        rd |-> (mem_addr[1:0] == 2'b00 && mem_addr[3:2] != 2'b11));

    a_r6_buffer_aligned: assert property (@(posedge clk) disable iff (rst)
        byte_wr |-> (buf_base[1:0] == 2'b10));

    a_r7_within_capacity: assert property (@(posedge clk) disable iff (rst)
        byte_wr |-> ((mem_addr - buf_base) < AW'(cap_q)));
endmodule

bind rxr_ring_writer rxr_ring_writer_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .in_ready(in_ready), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .buf_base(buf_base), .cap_q(cap_q)
);

// File: tb/rxr_ring_writer_bench.sv
module rxr_ring_writer_bench;
    localparam int AW = 32;
    localparam int MINL = 8;

    logic clk = 1'b0, rst = 1'b1, en = 1'b1, accept_all = 1'b0, accept_runt = 1'b0;
    logic [AW-1:0] ring_base = '0;
    logic in_valid = 1'b0, in_last = 1'b0, in_err = 1'b0, in_ready;
    logic [7:0] in_data = '0;
    logic mem_req, mem_we, mem_rvalid = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata = '0;
    logic [3:0] mem_be;

    logic [31:0] mem [256];
    int n_rd = 0, n_wb = 0, n_ww = 0;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rxr_ring_writer #(.AW(AW), .MIN_LEN(MINL)) u_rxr_ring_writer (
        .clk(clk), .rst(rst), .en(en), .accept_all(accept_all),
        .accept_runt(accept_runt), .ring_base(ring_base), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .in_err(in_err), .in_ready(in_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata)
    );

    // memory model: writes land at the edge, read data one cycle later
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
                if (mem_be == 4'hF) n_ww++; else n_wb++;
            end else begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[mem_addr[9:2]];
                n_rd++;
            end
        end
    end

    function automatic logic [7:0] get_byte(input logic [31:0] a);
        return mem[a[9:2]][8*a[1:0] +: 8];
    endfunction

    function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
        return seed + 8'(i * 3);
    endfunction

    function automatic logic [31:0] bufa(input int d);
        return 32'h102 + 32'h80 * d;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic send_frame(input int len, input bit err_last, input logic [7:0] seed);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = pat(seed, i);
            in_last  = (i == len - 1);
            in_err   = err_last && (i == len - 1);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_data(input string req, input int d, input int n, input logic [7:0] seed);
        int bad = 0;
        for (int i = 0; i < n; i++)
            if (get_byte(bufa(d) + 32'(i)) !== pat(seed, i)) bad++;
        check(req, "buffer bytes wrong", 32'(bad), 32'd0);
    endtask

    // {len[8], err, accept_all, accept_runt, slot[2], expected word0[32]}
    localparam int NV = 9;
    localparam logic [44:0] VEC [NV] = '{
        {8'd12, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0000_000C},  // R4 plain
        {8'd20, 1'b0, 1'b0, 1'b0, 2'd1, 32'h0000_0014},  // R5 advance
        {8'd5,  1'b0, 1'b0, 1'b1, 2'd2, 32'h0002_0005},  // R9 runt kept
        {8'd9,  1'b1, 1'b1, 1'b0, 2'd0, 32'h0001_0009},  // R8 kept, R5 wrap
        {8'd10, 1'b1, 1'b0, 1'b0, 2'd1, 32'h8000_0000},  // R8 discarded
        {8'd4,  1'b0, 1'b0, 1'b0, 2'd1, 32'h8000_0000},  // R9 discarded
        {8'd8,  1'b0, 1'b0, 1'b0, 2'd1, 32'h0000_0008},  // R9 boundary, same slot
        {8'd7,  1'b1, 1'b1, 1'b1, 2'd2, 32'h0003_0007},  // R8 R9 both flags
        {8'd1,  1'b0, 1'b1, 1'b1, 2'd0, 32'h0002_0001}   // R5 wrap again
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int rd0, wb0, ww0;
        for (int w = 0; w < 256; w++) mem[w] = '0;
        for (int d = 0; d < 3; d++) begin
            mem[d*4]     = 32'h8000_0000;
            mem[d*4 + 1] = (d == 2) ? 32'h8000_0040 : 32'h0000_0040;
            mem[d*4 + 2] = bufa(d);
        end

        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1", "in_ready in reset", 32'(in_ready), 0);
        check("R1", "mem_req in reset", 32'(mem_req), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "mem_req after reset", 32'(mem_req), 0);

        for (int v = 0; v < NV; v++) begin
            logic [7:0] len; logic e, aa, ar; logic [1:0] d; logic [31:0] w0;
            {len, e, aa, ar, d, w0} = VEC[v];
            accept_all = aa; accept_runt = ar;
            send_frame(int'(len), e, 8'(8'h20 + v));
            check("R4", $sformatf("vector %0d word0", v), mem[d*4], w0);
            if (!w0[31]) begin
                check_data("R3", int'(d), int'(len), 8'(8'h20 + v));
                mem[d*4] = 32'h8000_0000;
            end
        end
        accept_all = 1'b0; accept_runt = 1'b0;

        // R2: slot 1 owned by software, frame must wait
        mem[4] = 32'h0;
        ww0 = n_ww; wb0 = n_wb;
        @(negedge clk);
        in_valid = 1'b1; in_data = pat(8'h40, 0);
        begin
            int seen = 0;
            repeat (20) begin @(negedge clk); if (in_ready) seen++; end
            check("R2", "in_ready while unowned", 32'(seen), 0);
        end
        check("R2", "writes while unowned", 32'(n_ww + n_wb - ww0 - wb0), 0);
        mem[4] = 32'h8000_0000;
        send_frame(10, 1'b0, 8'h40);
        check("R2", "word0 after ownership returned", mem[4], 32'h0000_000A);
        check_data("R2", 1, 10, 8'h40);

        // R6: 4-byte aligned buffer on slot 2
        mem[10] = 32'h204; mem[8] = 32'h8000_0000;
        wb0 = n_wb;
        send_frame(10, 1'b0, 8'h50);
        check("R6", "word0 word-aligned buffer", mem[8], 32'h0008_000A);
        check("R6", "byte writes to bad buffer", 32'(n_wb - wb0), 0);
        mem[10] = bufa(2);
        // R6: odd buffer on slot 0 (ring wrapped)
        mem[2] = 32'h103; mem[0] = 32'h8000_0000;
        wb0 = n_wb;
        send_frame(9, 1'b0, 8'h58);
        check("R6", "word0 odd buffer", mem[0], 32'h0008_0009);
        check("R6", "byte writes to odd buffer", 32'(n_wb - wb0), 0);
        mem[2] = bufa(0);

        // R7: capacity 6 on slot 1
        mem[5] = 32'h6; mem[4] = 32'h8000_0000;
        for (int w = 8'h60; w < 8'h64; w++) mem[w] = 32'hEEEE_EEEE;
        wb0 = n_wb;
        send_frame(10, 1'b0, 8'h11);
        check("R7", "word0 overflow", mem[4], 32'h0004_000A);
        check_data("R7", 1, 6, 8'h11);
        check("R7", "byte past capacity", 32'(get_byte(bufa(1) + 6)), 32'hEE);
        check("R7", "byte write count", 32'(n_wb - wb0), 6);
        mem[5] = 32'h40;

        // R10: disable while a frame waits; pointer parks at ring base
        mem[0] = 32'h8000_0000; mem[8] = 32'h8000_0000;
        @(negedge clk);
        en = 1'b0;
        rd0 = n_rd;
        @(negedge clk);
        in_valid = 1'b1; in_data = pat(8'h70, 0);
        begin
            int seen = 0;
            repeat (10) begin @(negedge clk); if (in_ready) seen++; end
            check("R10", "in_ready while disabled", 32'(seen), 0);
        end
        check("R10", "reads while disabled", 32'(n_rd - rd0), 0);
        en = 1'b1;
        send_frame(9, 1'b0, 8'h70);
        check("R10", "frame lands in first slot", mem[0], 32'h0000_0009);
        check("R10", "slot 2 untouched", mem[8], 32'h8000_0000);
        check_data("R10", 0, 9, 8'h70);

        summary();
    end
endmodule